// File: doc/BRIEF.md
# Split-Capable Cluster Carry Chain

This block is the carry path through one cluster of arithmetic cells. The cluster has ten cells in two halves of five: an upper half (cells 1 to 5) and a lower half (cells 6 to 10). Each cell adds two operand bits, so a half is 10 bits wide and the whole cluster is 20 bits wide. Inside a cell the two bits are resolved by carry select. Both outcomes, for a carry of 0 and a carry of 1, are computed in advance, and the incoming carry only picks one of them. The delay through a cell is therefore one select rather than two ripple stages.

Clusters stacked in a column are linked through the carry-outs of the two halves. There are three ways to use a cluster:
- A chain can run the full 20 bits, from the upper half into the lower half.
- The two halves can act as independent 10-bit chains. Each half takes its carry from the same half of the cluster above and passes its carry to the same half of the cluster below.
- A chain can be launched fresh at cell 1 or at cell 6 from a column carry-in.

One half of the cluster can be bypassed, and a parameter selects which half, so that neighbouring columns can alternate. A bypassed half forwards its carry-in unchanged to its carry-out and drives zero sums. This frees that half's cells for other logic. The sums and both carry-outs are registered.

Top module: `carry_cluster`

## Requirements
- R1: While `rst_n` is low, `sum_o`, `cout_top_o` and `cout_bot_o` are all zero.
- R2: All outputs are registered. They change only at a rising clock edge and reflect the inputs sampled at that edge, so an input change between edges does not appear until the next edge.
- R3: The carry into the upper half is `launch_cin_i` when `start_top_i` is 1 (a chain begins at cell 1). Otherwise it is `cin_top_i`.
- R4: With `split_i`, `start_bot_i` and `bypass_i` all 0, the block adds the full width: {`cout_bot_o`, `sum_o`} = `op_a` + `op_b` + the upper carry-in from R3. `cout_top_o` is the carry out of bit 9. Bits 9..0 belong to the upper half, and cell k (k = 1..10) holds bits 2k-1 and 2k-2.
- R5: With `split_i` = 1 and `start_bot_i` = 0, the lower half takes its carry from `cin_bot_i` and ignores the upper half's carry-out: {`cout_bot_o`, `sum_o[19:10]`} = `op_a[19:10]` + `op_b[19:10]` + `cin_bot_i`.
- R6: With `start_bot_i` = 1 (a chain begins at cell 6), the lower half's carry-in is `launch_cin_i`. This takes priority over both `split_i` and the upper half's carry-out.
- R7: With `bypass_i` = 1, the half named by `BYP_HALF` is bypassed. The default is the upper half, value 0 (`BYP_TOP`); value 1 (`BYP_BOT`) names the lower half. A bypassed half drives its sum bits to zero, and its carry-out equals its carry-in.
- R8: Bypass leaves the other half computing normally. With the upper half bypassed, an unsplit lower half receives the forwarded upper carry-in. For example, `op_a[19:10]` + `op_b[19:10]` + the R3 carry appears on {`cout_bot_o`, `sum_o[19:10]`}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 20 | Operand A, bit 0 in cell 1 |
| op_b | input | 20 | Operand B |
| cin_top_i | input | 1 | Carry from the upper half of the cluster above |
| cin_bot_i | input | 1 | Carry from the lower half of the cluster above |
| launch_cin_i | input | 1 | Column carry-in for a chain starting in this cluster |
| start_top_i | input | 1 | Chain starts at cell 1 |
| start_bot_i | input | 1 | Chain starts at cell 6 |
| split_i | input | 1 | Halves run as independent chains |
| bypass_i | input | 1 | Bypass the half chosen by `BYP_HALF` |
| sum_o | output | 20 | Registered sum bits |
| cout_top_o | output | 1 | Registered carry out of the upper half |
| cout_bot_o | output | 1 | Registered carry out of the lower half |

## Verification
Several sources can claim the lower half's carry-in in the same cycle: a cell-6 launch, the split carry from the cluster above, and the upper half's carry. On top of that, a bypass can reroute the upper half's carry in that same cycle. The bench raises `start_bot_i` together with `split_i`, sets `bypass_i` together with `start_top_i`, and mixes all the controls at random. In each cycle it judges the lower sum and `cout_bot_o` against a priority model: a launch first, then the split carry, then the upper carry, which is forwarded unchanged when that half is bypassed.

// File: rtl/carry_cluster_pkg.sv
package carry_cluster_pkg;
   typedef enum logic {
      BYP_TOP = 1'b0,
      BYP_BOT = 1'b1
   } byp_half_e;

   localparam int unsigned CC_CELLS_PER_HALF = 5;
   localparam int unsigned CC_BITS_PER_CELL  = 2;
endpackage

// File: rtl/cc_cell.sv
module cc_cell #(
   parameter int unsigned W = 2
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o
);
   logic [W:0] res_c0;
   logic [W:0] res_c1;

   // both outcomes are ready before the carry arrives
   assign res_c0 = {1'b0, a_i} + {1'b0, b_i};
   assign res_c1 = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, 1'b1};

   assign sum_o  = cin_i ? res_c1[W-1:0] : res_c0[W-1:0];
   assign cout_o = cin_i ? res_c1[W]     : res_c0[W];
endmodule

// File: rtl/cc_half.sv
module cc_half #(
   parameter int unsigned CELLS      = 5,
   parameter int unsigned W          = 2,
   parameter bit          BYPASSABLE = 1'b0,
   localparam int unsigned HW        = CELLS * W
) (
   input  logic [HW-1:0] a_i,
   input  logic [HW-1:0] b_i,
   input  logic          cin_i,
   input  logic          bypass_i,
   output logic [HW-1:0] sum_o,
   output logic          cout_o
);
   logic [CELLS:0]  chain;
   logic [HW-1:0]   rip_sum;
   logic            byp_eff;

   assign chain[0] = cin_i;

   for (genvar k = 0; k < CELLS; k++) begin : g_cell
      cc_cell #(.W(W)) u_cell (
         .a_i   (a_i[k*W +: W]),
         .b_i   (b_i[k*W +: W]),
         .cin_i (chain[k]),
         .sum_o (rip_sum[k*W +: W]),
         .cout_o(chain[k+1])
      );
   end

   if (BYPASSABLE) begin : g_byp
      assign byp_eff = bypass_i;
   end else begin : g_fixed
      assign byp_eff = bypass_i & 1'b0;
   end

   assign sum_o  = byp_eff ? '0    : rip_sum;
   assign cout_o = byp_eff ? cin_i : chain[CELLS];
endmodule

// File: rtl/carry_cluster.sv
module carry_cluster
   import carry_cluster_pkg::*;
#(
   parameter int unsigned CELLS_PER_HALF = CC_CELLS_PER_HALF,
   parameter int unsigned BITS_PER_CELL  = CC_BITS_PER_CELL,
   parameter byp_half_e   BYP_HALF       = BYP_TOP,
   localparam int unsigned HALF_W        = CELLS_PER_HALF * BITS_PER_CELL,
   localparam int unsigned W             = 2 * HALF_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   input  logic         cin_top_i,
   input  logic         cin_bot_i,
   input  logic         launch_cin_i,
   input  logic         start_top_i,
   input  logic         start_bot_i,
   input  logic         split_i,
   input  logic         bypass_i,
   output logic [W-1:0] sum_o,
   output logic         cout_top_o,
   output logic         cout_bot_o
);
   if (CELLS_PER_HALF < 1) begin : g_bad_cells
      $error("carry_cluster: CELLS_PER_HALF must be at least 1");
   end
   if (BITS_PER_CELL < 1) begin : g_bad_bits
      $error("carry_cluster: BITS_PER_CELL must be at least 1");
   end

   logic              top_cin, bot_cin;
   logic              top_cout, bot_cout;
   logic [HALF_W-1:0] top_sum, bot_sum;

   assign top_cin = start_top_i ? launch_cin_i : cin_top_i;

   cc_half #(
      .CELLS     (CELLS_PER_HALF),
      .W         (BITS_PER_CELL),
      .BYPASSABLE(BYP_HALF == BYP_TOP)
   ) u_top (
      .a_i     (op_a[HALF_W-1:0]),
      .b_i     (op_b[HALF_W-1:0]),
      .cin_i   (top_cin),
      .bypass_i(bypass_i),
      .sum_o   (top_sum),
      .cout_o  (top_cout)
   );

   // launch at cell 6 beats the split carry, which beats the upper carry
   always_comb begin
      if (start_bot_i)  bot_cin = launch_cin_i;
      else if (split_i) bot_cin = cin_bot_i;
      else              bot_cin = top_cout;
   end

   cc_half #(
      .CELLS     (CELLS_PER_HALF),
      .W         (BITS_PER_CELL),
      .BYPASSABLE(BYP_HALF == BYP_BOT)
   ) u_bot (
      .a_i     (op_a[W-1:HALF_W]),
      .b_i     (op_b[W-1:HALF_W]),
      .cin_i   (bot_cin),
      .bypass_i(bypass_i),
      .sum_o   (bot_sum),
      .cout_o  (bot_cout)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_o      <= '0;
         cout_top_o <= 1'b0;
         cout_bot_o <= 1'b0;
      end else begin
         sum_o      <= {bot_sum, top_sum};
         cout_top_o <= top_cout;
         cout_bot_o <= bot_cout;
      end
   end
endmodule

// File: rtl/carry_cluster_chk.sv
module carry_cluster_chk
   import carry_cluster_pkg::*;
#(
   parameter int unsigned CELLS_PER_HALF = CC_CELLS_PER_HALF,
   parameter int unsigned BITS_PER_CELL  = CC_BITS_PER_CELL,
   parameter byp_half_e   BYP_HALF       = BYP_TOP,
   localparam int unsigned HALF_W        = CELLS_PER_HALF * BITS_PER_CELL,
   localparam int unsigned W             = 2 * HALF_W
) (
   input logic         clk,
   input logic         rst_n,
   input logic [W-1:0] op_a,
   input logic [W-1:0] op_b,
   input logic         cin_top_i,
   input logic         cin_bot_i,
   input logic         launch_cin_i,
   input logic         start_top_i,
   input logic         start_bot_i,
   input logic         split_i,
   input logic         bypass_i,
   input logic [W-1:0] sum_o,
   input logic         cout_top_o,
   input logic         cout_bot_o
);
   logic            up_c;
   logic            byp_top, byp_bot;
   logic [W:0]      full_ref;
   logic [HALF_W:0] lo_ref, hi_split_ref, hi_launch_ref, hi_fwd_ref;

   assign up_c    = start_top_i ? launch_cin_i : cin_top_i;
   assign byp_top = bypass_i && (BYP_HALF == BYP_TOP);
   assign byp_bot = bypass_i && (BYP_HALF == BYP_BOT);

   assign full_ref      = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, up_c};
   assign lo_ref        = {1'b0, op_a[HALF_W-1:0]} + {1'b0, op_b[HALF_W-1:0]}
                          + {{HALF_W{1'b0}}, up_c};
   assign hi_split_ref  = {1'b0, op_a[W-1:HALF_W]} + {1'b0, op_b[W-1:HALF_W]}
                          + {{HALF_W{1'b0}}, cin_bot_i};
   assign hi_launch_ref = {1'b0, op_a[W-1:HALF_W]} + {1'b0, op_b[W-1:HALF_W]}
                          + {{HALF_W{1'b0}}, launch_cin_i};
   assign hi_fwd_ref    = {1'b0, op_a[W-1:HALF_W]} + {1'b0, op_b[W-1:HALF_W]}
                          + {{HALF_W{1'b0}}, up_c};

   // R1 outputs cleared under reset
   always @(negedge clk) begin
      if (!rst_n) begin
         a_r1_reset_zero: assert (sum_o == '0 && !cout_top_o && !cout_bot_o);
      end
   end

   // R3 R4 full-width sum with selected upper carry-in
   a_r4_full_sum: assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass_i && !split_i && !start_bot_i)
      |=> ({cout_bot_o, sum_o} == $past(full_ref)));

   // R5 split lower half uses its own carry-in
   a_r5_split_lower: assert property (@(posedge clk) disable iff (!rst_n)
      (split_i && !start_bot_i && !byp_bot)
      |=> ({cout_bot_o, sum_o[W-1:HALF_W]} == $past(hi_split_ref)));

   // R6 cell-6 launch has priority
   a_r6_start_lower: assert property (@(posedge clk) disable iff (!rst_n)
      (start_bot_i && !byp_bot)
      |=> ({cout_bot_o, sum_o[W-1:HALF_W]} == $past(hi_launch_ref)));

   // R7 bypassed upper half: zero sums, carry forwarded
   a_r7_bypass_top: assert property (@(posedge clk) disable iff (!rst_n)
      byp_top |=> (sum_o[HALF_W-1:0] == '0 && cout_top_o == $past(up_c)));

   // R7 bypassed lower half: zero sums
   a_r7_bypass_bot: assert property (@(posedge clk) disable iff (!rst_n)
      byp_bot |=> (sum_o[W-1:HALF_W] == '0));

   // R8 the other half still adds
   a_r8_lower_after_byp: assert property (@(posedge clk) disable iff (!rst_n)
      (byp_top && !split_i && !start_bot_i)
      |=> ({cout_bot_o, sum_o[W-1:HALF_W]} == $past(hi_fwd_ref)));

   a_r8_upper_after_byp: assert property (@(posedge clk) disable iff (!rst_n)
      byp_bot |=> ({cout_top_o, sum_o[HALF_W-1:0]} == $past(lo_ref)));
endmodule

bind carry_cluster carry_cluster_chk #(
   .CELLS_PER_HALF(CELLS_PER_HALF),
   .BITS_PER_CELL (BITS_PER_CELL),
   .BYP_HALF      (BYP_HALF)
) u_chk (.*);

// File: tb/tb_carry_cluster.sv
`timescale 1ns/1ps
module tb_carry_cluster;
   localparam int W  = 20;
   localparam int HW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [W-1:0]  op_a = '0, op_b = '0;
   logic          cin_top_i = 0, cin_bot_i = 0, launch_cin_i = 0;
   logic          start_top_i = 0, start_bot_i = 0, split_i = 0, bypass_i = 0;
   logic [W-1:0]  sum_o;
   logic          cout_top_o, cout_bot_o;

   int            n_checks = 0;
   int            n_fail   = 0;
   bit            done     = 0;

   logic [W+1:0]  exp_q = '0;
   string         exp_tag = "R1";

   always #2 clk = ~clk;

   carry_cluster dut (
      .clk, .rst_n, .op_a, .op_b, .cin_top_i, .cin_bot_i, .launch_cin_i,
      .start_top_i, .start_bot_i, .split_i, .bypass_i,
      .sum_o, .cout_top_o, .cout_bot_o
   );

   // behavioural reference: returns {cout_bot, cout_top, sum}
   function automatic logic [W+1:0] model();
      int unsigned tc, bc, lo, hi, ct;
      tc = start_top_i ? launch_cin_i : cin_top_i;
      if (bypass_i) begin
         lo = 0;
         ct = tc;
      end else begin
         lo = int'(op_a[HW-1:0]) + int'(op_b[HW-1:0]) + tc;
         ct = lo >> HW;
         lo = lo & 32'h3ff;
      end
      if (start_bot_i)  bc = launch_cin_i;
      else if (split_i) bc = cin_bot_i;
      else              bc = ct;
      hi = int'(op_a[W-1:HW]) + int'(op_b[W-1:HW]) + bc;
      return {hi[HW], ct[0], hi[HW-1:0], lo[HW-1:0]};
   endfunction

   function automatic string tag_now();
      if (start_bot_i) return "R6";
      if (bypass_i)    return "R7 R8";
      if (split_i)     return "R5";
      if (start_top_i) return "R3";
      return "R4";
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         exp_q   = '0;
         exp_tag = "R1";
      end else begin
         exp_q   = model();
         exp_tag = tag_now();
      end
   end

   task automatic check(input string tag, input logic [W+1:0] act, input logic [W+1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [W+1:0] outs();
      return {cout_bot_o, cout_top_o, sum_o};
   endfunction

   task automatic step(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic ct, input logic cb, input logic l,
                       input logic st, input logic sb, input logic sp, input logic by);
      @(negedge clk);
      check(exp_tag, outs(), exp_q);
      op_a = a; op_b = b; cin_top_i = ct; cin_bot_i = cb; launch_cin_i = l;
      start_top_i = st; start_bot_i = sb; split_i = sp; bypass_i = by;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1", outs(), '0);                         // R1 under reset, inputs idle
      op_a = 20'hFFFFF; op_b = 20'h00001;
      @(negedge clk);
      check("R1", outs(), '0);                         // R1 still zero with live inputs
      rst_n = 1'b1;
      op_a = '0; op_b = '0;

      // R3 R4 launch at cell 1, carry ripples through all twenty bits
      step(20'hFFFFF, 20'h00000, 0, 0, 1, 1, 0, 0, 0);
      // R2: one unit after the change outputs still show the previous result
      @(negedge clk);
      check(exp_tag, outs(), exp_q);
      op_a = 20'h00001; op_b = 20'h00001;
      #1 check("R2", outs(), exp_q);
      // R3 upper carry from cin_top_i
      step(20'h003FF, 20'h00000, 1, 0, 0, 0, 0, 0, 0);
      step(20'h12345, 20'h0ABCD, 0, 0, 1, 0, 0, 0, 0);  // R3 launch ignored when not starting
      // R5 split: lower half ignores the upper carry
      step(20'h017FF, 20'h01C01, 1, 0, 0, 0, 0, 1, 0);
      step(20'hFFC00, 20'h00400, 0, 1, 0, 0, 0, 1, 0);
      // R6 cell-6 launch beats split and upper carry
      step(20'h003FF, 20'h00001, 1, 0, 1, 0, 1, 1, 0);
      step(20'hFFFFF, 20'h00001, 0, 1, 0, 1, 1, 0, 0);
      // R7 R8 bypassed upper half
      step(20'hFFFFF, 20'h00001, 1, 0, 0, 0, 0, 0, 0);
      step(20'hFFFFF, 20'h00001, 1, 0, 0, 0, 0, 0, 1);
      step(20'h7FFFF, 20'h00000, 0, 0, 1, 1, 0, 0, 1);
      step(20'hAAAAA, 20'h55555, 1, 0, 0, 0, 0, 1, 1);
      step(20'h12345, 20'h6789A, 0, 1, 1, 0, 1, 0, 1);

      for (int i = 0; i < 400; i++) begin
         step(20'($urandom), 20'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      end
      step('0, '0, 0, 0, 0, 0, 0, 0, 0);
      step('0, '0, 0, 0, 0, 0, 0, 0, 0);

      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule